// File: doc/BRIEF.md
# GPIO interrupt detect and summary

This block turns a bank of already-filtered GPIO input levels into interrupt events. Each pin has a 32-bit control word. Software uses it to pick edge or level detection and the polarity or edges of interest. It also holds separate enable and unmask bits, a sticky interrupt status bit and a sticky wake status bit. Both status bits are cleared by writing back the word that was read.

Pending pins are folded into a summary vector with one bit for every four pins, so a handler can find the busy quad quickly. The summary is split over two 32-bit words, low word first. All pending sources are merged into one parent interrupt line, which gives a single one-clock pulse and then stays quiet. It fires again only after software writes the end-of-interrupt bit in the master word, and it fires at once at that point if anything is still pending.

Access goes through a plain register port. A write lands on the clock edge where `wr_en` is high. A read returns data one cycle after `rd_en`.

Top module: `gpio_irq_summary`

## Requirements
- R1: After synchronous reset every pin word, both summary words and `rdata` read zero, and `irq_out` is low.
- R2: Pin n's word sits at byte offset 4*n. Its fields are: bit0 mode (1 = level, 0 = edge), bits[2:1] polarity code, bit3 enable, bit4 unmask (1 = unmasked), bit8 interrupt status, bit9 wake status. Config bits read back as written. Bits 5-7 and 10-31 read zero, and a write can never set a status bit.
- R3: In edge mode, polarity code 00 sets status on a falling input, 01 on a rising input and 10 on either edge.
- R4: In level mode, code 01 sets status while the input is high and code 00 while it is low. A clear made while the level is still active is overridden, so status stays 1.
- R5: A pin whose enable bit is 0 never sets its interrupt status.
- R6: With unmask = 0, status is still captured, but it does not reach the summary or `irq_out`. Setting unmask later reports the captured status.
- R7: Writing a 1 to bit8 or bit9 of a pin word clears that status bit. Writing a 0 leaves it unchanged.
- R8: Summary bit k is high when any of pins 4k..4k+3 is pending. A pin is pending when its interrupt status, enable and unmask bits are all set, or when its wake status is set. Bits 0-31 read at offset 0x400 and bits 32-45 at offset 0x404.
- R9: A high `pin_wake` bit sets that pin's wake status whatever the pin's configuration, and wake status counts as pending.
- R10: When the line is armed and something is pending, `irq_out` gives exactly one pulse, one clock wide, and then disarms.
- R11: Writing 1 to bit0 at offset 0x408 re-arms the line. A new pulse follows at once if anything is still pending, and nothing happens if nothing is pending.
- R12: A read returns its data on `rdata` in the cycle after `rd_en`. Reads of unmapped or unaligned addresses, and all other cycles, give zero.
- R13: Edge mode with code 11, and level mode with code 10 or 11, never set status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl | input | NUM_PINS | Filtered pin levels |
| pin_wake | input | NUM_PINS | Per-pin wake event, high for one clock per event |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_out | output | 1 | Parent interrupt pulse |

## Verification
The detector is driven with rising, falling and double transitions on pins set to each edge code, and with held high and low levels on pins in level mode. These patterns show that each polarity code picks only its own transitions, and that a level source re-sets status after a clear while a pulsed edge source does not. Pins that are disabled, masked or given a reserved code see the same transitions, which separates capture from delivery and from rejection. Two pins of one quad are cleared one at a time to show the OR grouping. End-of-interrupt is written both with and without pending work to show the re-arm rule.

// File: rtl/gis_pkg.sv
// Shared field positions and types for the GPIO interrupt block.
// Assumes a 32-bit pin word whose low five bits hold the config struct.
package gis_pkg;
    localparam int BIT_INT_STS  = 8;
    localparam int BIT_WAKE_STS = 9;
    localparam int SUM_GRP_MAX  = 46;
    localparam int SUM_W        = 64;
    localparam int CFG_W        = 5;

    typedef enum logic [1:0] {
        POL_LOW  = 2'b00,
        POL_HIGH = 2'b01,
        POL_BOTH = 2'b10,
        POL_RSVD = 2'b11
    } pol_e;

    // Packed so that bit 0 is the mode and bit 4 the unmask, matching the word.
    typedef struct packed {
        logic unmask;
        logic en;
        pol_e pol;
        logic lvl_mode;
    } pin_cfg_t;
endpackage

// File: rtl/gis_pin_det.sv
// One pin's detector: config register, edge history, sticky interrupt
// and wake status with write-1-to-clear. A new event wins over a clear
// that arrives in the same cycle. Assumes pin_lvl is already filtered.
module gis_pin_det
    import gis_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin_lvl,
    input  logic     pin_wake,
    input  logic     wr_sel,
    input  pin_cfg_t cfg_wr,
    input  logic     clr_int,
    input  logic     clr_wake,
    output pin_cfg_t cfg_o,
    output logic     int_sts_o,
    output logic     wake_sts_o,
    output logic     pend_o
);
    pin_cfg_t cfg_q;
    logic     prev_q;
    logic     int_q;
    logic     wake_q;
    logic     hit;
    logic     rise;
    logic     fall;

    // Transition and level match for the selected polarity and mode.
    always_comb begin
        rise = pin_lvl & ~prev_q;
        fall = ~pin_lvl & prev_q;
        unique case (cfg_q.pol)
            POL_LOW:  hit = cfg_q.lvl_mode ? ~pin_lvl : fall;
            POL_HIGH: hit = cfg_q.lvl_mode ? pin_lvl  : rise;
            POL_BOTH: hit = cfg_q.lvl_mode ? 1'b0     : (rise | fall);
            default:  hit = 1'b0;
        endcase
    end

    // Config storage and input history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            prev_q <= 1'b0;
        end else begin
            prev_q <= pin_lvl;
            if (wr_sel) cfg_q <= cfg_wr;
        end
    end

    // Sticky status bits: set by events, cleared by writing ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q  <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            int_q  <= (int_q & ~(wr_sel & clr_int)) | (cfg_q.en & hit);
            wake_q <= (wake_q & ~(wr_sel & clr_wake)) | pin_wake;
        end
    end

    assign cfg_o      = cfg_q;
    assign int_sts_o  = int_q;
    assign wake_sts_o = wake_q;
    assign pend_o     = (int_q & cfg_q.en & cfg_q.unmask) | wake_q;
endmodule

// File: rtl/gis_summary.sv
// Folds per-pin pending flags into one bit per group of four pins and
// a global any-pending flag. Assumes NUM_PINS fits the 46-bit summary.
module gis_summary
    import gis_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic [NUM_PINS-1:0] pend,
    output logic [SUM_W-1:0]    sum_vec,
    output logic                any_pend
);
    localparam int NUM_GRP = (NUM_PINS + 3) / 4;

    for (genvar k = 0; k < NUM_GRP; k++) begin : g_grp
        localparam int LO = 4 * k;
        localparam int HI = (4 * k + 3 < NUM_PINS) ? 4 * k + 3 : NUM_PINS - 1;
        assign sum_vec[k] = |pend[HI:LO];
    end
    if (NUM_GRP < SUM_W) begin : g_pad
        assign sum_vec[SUM_W-1:NUM_GRP] = '0;
    end

    assign any_pend = |pend;
endmodule

// File: rtl/gis_parent_irq.sv
// Parent line control: one pulse per arming, re-armed by end-of-interrupt.
// A fire in the same cycle as end-of-interrupt takes priority.
module gis_parent_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic any_pend,
    input  logic eoi_wr,
    output logic irq_out,
    output logic armed
);
    logic fire;

    assign fire = armed & any_pend;

    // Arming state and registered pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed   <= 1'b1;
            irq_out <= 1'b0;
        end else begin
            irq_out <= fire;
            if (fire)        armed <= 1'b0;
            else if (eoi_wr) armed <= 1'b1;
        end
    end
endmodule

// File: rtl/gpio_irq_summary.sv
// Top of the GPIO interrupt detect and summary block: address decode,
// per-pin detectors, group summary, parent line and registered read port.
// Assumes byte addresses; pin words at 4*n, summary and master words above.
module gpio_irq_summary
    import gis_pkg::*;
#(
    parameter int          NUM_PINS   = 16,
    parameter int          ADDR_W     = 12,
    parameter int unsigned SUM_LO_OFF = 'h400,
    parameter int unsigned SUM_HI_OFF = 'h404,
    parameter int unsigned MASTER_OFF = 'h408,
    parameter int          EOI_BIT    = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_lvl,
    input  logic [NUM_PINS-1:0] pin_wake,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    output logic                irq_out
);
    logic [NUM_PINS-1:0] wr_sel;
    logic [NUM_PINS-1:0] pend;
    logic [NUM_PINS-1:0] int_vec;
    logic [NUM_PINS-1:0] wake_vec;
    logic [NUM_PINS-1:0] en_vec;
    pin_cfg_t            cfg_arr [NUM_PINS];
    logic [SUM_W-1:0]    sum_vec;
    logic                any_pend;
    logic                armed;
    logic                eoi_wr;
    logic [31:0]         rd_mux;
    pin_cfg_t            cfg_wr;

    assign cfg_wr = pin_cfg_t'(wdata[CFG_W-1:0]);

    // Write decode: one select per pin word, plus the end-of-interrupt strobe.
    always_comb begin
        for (int n = 0; n < NUM_PINS; n++) begin
            wr_sel[n] = wr_en && (addr == ADDR_W'(4 * n));
        end
        eoi_wr = wr_en && (addr == ADDR_W'(MASTER_OFF)) && wdata[EOI_BIT];
    end

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        gis_pin_det u_pin (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_lvl    (pin_lvl[n]),
            .pin_wake   (pin_wake[n]),
            .wr_sel     (wr_sel[n]),
            .cfg_wr     (cfg_wr),
            .clr_int    (wdata[BIT_INT_STS]),
            .clr_wake   (wdata[BIT_WAKE_STS]),
            .cfg_o      (cfg_arr[n]),
            .int_sts_o  (int_vec[n]),
            .wake_sts_o (wake_vec[n]),
            .pend_o     (pend[n])
        );
        assign en_vec[n] = cfg_arr[n].en;
    end

    gis_summary #(
        .NUM_PINS (NUM_PINS)
    ) u_sum (
        .pend     (pend),
        .sum_vec  (sum_vec),
        .any_pend (any_pend)
    );

    gis_parent_irq u_parent (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_pend (any_pend),
        .eoi_wr   (eoi_wr),
        .irq_out  (irq_out),
        .armed    (armed)
    );

    // Read select: pin words, then the two summary halves; the master word reads zero.
    always_comb begin
        rd_mux = '0;
        for (int n = 0; n < NUM_PINS; n++) begin
            if (addr == ADDR_W'(4 * n)) begin
                rd_mux[CFG_W-1:0]    = cfg_arr[n];
                rd_mux[BIT_INT_STS]  = int_vec[n];
                rd_mux[BIT_WAKE_STS] = wake_vec[n];
            end
        end
        if (addr == ADDR_W'(SUM_LO_OFF)) rd_mux = sum_vec[31:0];
        if (addr == ADDR_W'(SUM_HI_OFF)) rd_mux = sum_vec[63:32];
    end

    // Registered read data, zero when no read was requested.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
        else            rdata <= '0;
    end
endmodule

// File: rtl/gpio_irq_summary_chk.sv
// Property checker for gpio_irq_summary, attached by bind below.
// Observes the parent line, arming state, decode strobes and pin status.
module gpio_irq_summary_chk #(
    parameter int NUM_PINS = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rd_en,
    input logic [31:0]         rdata,
    input logic                irq_out,
    input logic                armed,
    input logic                any_pend,
    input logic                eoi_wr,
    input logic [NUM_PINS-1:0] int_vec,
    input logic [NUM_PINS-1:0] en_vec
);
    // R10: the parent pulse is one clock wide.
    p_single_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |=> !irq_out);

    // R10: an armed line with pending work fires on the next clock.
    p_fire_when_armed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && any_pend) |=> irq_out);

    // R11: a disarmed line stays quiet unless end-of-interrupt arrives.
    p_quiet_until_eoi_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !eoi_wr) |=> !irq_out);

    // R11: end-of-interrupt re-arms when no fire competes.
    p_eoi_rearms_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !(armed && any_pend)) |=> armed);

    // R12: read data is zero in cycles that follow no read.
    p_rdata_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> (rdata == 32'h0));

    // R5: status rises only on a pin that was enabled.
    for (genvar n = 0; n < NUM_PINS; n++) begin : g_en
        p_status_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(int_vec[n]) |-> $past(en_vec[n]));
    end
endmodule

bind gpio_irq_summary gpio_irq_summary_chk #(
    .NUM_PINS (NUM_PINS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .irq_out  (irq_out),
    .armed    (armed),
    .any_pend (any_pend),
    .eoi_wr   (eoi_wr),
    .int_vec  (int_vec),
    .en_vec   (en_vec)
);

// File: tb/test_gpio_irq_summary.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares.
module test_gpio_irq_summary;
    localparam int NP   = 16;
    localparam int AW   = 12;
    localparam logic [AW-1:0] A_SLO = 12'h400;
    localparam logic [AW-1:0] A_SHI = 12'h404;
    localparam logic [AW-1:0] A_MST = 12'h408;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_lvl = '0;
    logic [NP-1:0] pin_wake = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq_out;

    int   n_vec = 0;
    int   n_bad = 0;
    int   irq_cnt = 0;
    logic rd_d = 1'b0;
    bit   done = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    gpio_irq_summary #(.NUM_PINS(NP), .ADDR_W(AW)) i_gpio_irq_summary (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .pin_wake(pin_wake),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_out(irq_out)
    );

    always #10 clk = ~clk;

    always @(posedge clk) rd_d <= rd_en;

    always @(negedge clk) if (irq_out) irq_cnt <= irq_cnt + 1;

    // Monitor: pop one expected word for every read issued.
    always @(negedge clk) begin
        if (rd_d) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if (rdata !== e) begin
                n_bad++;
                $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pin(input int i, input logic v);
        @(negedge clk);
        pin_lvl[i] = v;
        tick(3);
    endtask

    task automatic chk(input int act, input int exp, input string t);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got=%0d expected=%0d", t, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] pa(input int n);
        return AW'(4 * n);
    endfunction

    initial begin
        int base;
        tick(3);
        chk(int'(irq_out), 0, "R1 irq in reset");
        chk(int'(rdata), 0, "R1 rdata in reset");
        @(negedge clk) rst_n = 1'b1;
        rd(pa(0), 32'h0, "R1 pin0 after reset");
        rd(A_SLO, 32'h0, "R1 summary after reset");

        // R2 / R13: layout, write-only status, reserved edge code
        wr(pa(5), 32'hFFFF_FC1E);
        rd(pa(5), 32'h1E, "R2 readback");
        rd(pa(4), 32'h0, "R12 neighbour untouched");
        pin(5, 1'b1); pin(5, 1'b0);
        rd(pa(5), 32'h1E, "R13 edge code 11 inert");
        wr(pa(5), 32'h300);

        // R3 rising, R10 single pulse
        base = irq_cnt;
        wr(pa(2), 32'h1A);
        pin(2, 1'b1);
        rd(pa(2), 32'h11A, "R3 rising sets");
        chk(irq_cnt - base, 1, "R10 first pulse");
        tick(5);
        chk(irq_cnt - base, 1, "R10 no second pulse");
        rd(A_SLO, 32'h1, "R8 group0");
        wr(pa(2), 32'h11A);
        rd(pa(2), 32'h1A, "R7 write-back clears");
        pin(2, 1'b0);
        rd(pa(2), 32'h1A, "R3 falling ignored on rising");

        // R11 end-of-interrupt
        base = irq_cnt;
        wr(A_MST, 32'h1);
        tick(4);
        chk(irq_cnt - base, 0, "R11 eoi idle no pulse");
        pin(2, 1'b1);
        chk(irq_cnt - base, 1, "R11 rearmed pulse");
        wr(pa(2), 32'h1A);
        rd(pa(2), 32'h11A, "R7 zero write keeps status");
        wr(A_MST, 32'h1);
        tick(3);
        chk(irq_cnt - base, 2, "R11 eoi with pending refires");
        rd(A_MST, 32'h0, "R12 master reads zero");
        wr(pa(2), 32'h300);
        rd(pa(2), 32'h0, "R7 clear and disable");
        pin(2, 1'b0);

        // R3 falling
        wr(pa(3), 32'h18);
        pin(3, 1'b1);
        rd(pa(3), 32'h18, "R3 rising ignored on falling");
        pin(3, 1'b0);
        rd(pa(3), 32'h118, "R3 falling sets");
        wr(pa(3), 32'h300);

        // R3 both edges
        wr(pa(6), 32'h1C);
        pin(6, 1'b1);
        rd(pa(6), 32'h11C, "R3 both rise");
        rd(A_SLO, 32'h2, "R8 group1");
        wr(pa(6), 32'h11C);
        rd(pa(6), 32'h1C, "R7 clear both");
        pin(6, 1'b0);
        rd(pa(6), 32'h11C, "R3 both fall");
        wr(pa(6), 32'h300);

        // R4 level high and low
        wr(pa(7), 32'h1B);
        tick(2);
        rd(pa(7), 32'h1B, "R4 high inactive");
        pin(7, 1'b1);
        rd(pa(7), 32'h11B, "R4 high sets");
        wr(pa(7), 32'h11B);
        rd(pa(7), 32'h11B, "R4 clear overridden");
        pin(7, 1'b0);
        wr(pa(7), 32'h11B);
        rd(pa(7), 32'h1B, "R4 clear after release");
        wr(pa(7), 32'h300);
        wr(pa(8), 32'h19);
        tick(2);
        rd(pa(8), 32'h119, "R4 low sets");
        pin(8, 1'b1);
        wr(pa(8), 32'h119);
        rd(pa(8), 32'h19, "R4 low released");
        wr(pa(8), 32'h300);
        pin(8, 1'b0);

        // R13 level with both code
        wr(pa(9), 32'h1D);
        pin(9, 1'b1); pin(9, 1'b0);
        rd(pa(9), 32'h1D, "R13 level code 10 inert");
        wr(pa(9), 32'h300);

        // R5 disabled pin
        wr(pa(10), 32'h12);
        pin(10, 1'b1); pin(10, 1'b0);
        rd(pa(10), 32'h12, "R5 disabled no status");
        rd(A_SLO, 32'h0, "R5 summary quiet");
        wr(pa(10), 32'h0);

        // R6 masked capture then unmask
        wr(A_MST, 32'h1);
        base = irq_cnt;
        wr(pa(12), 32'h0A);
        pin(12, 1'b1);
        rd(pa(12), 32'h10A, "R6 masked captures");
        rd(A_SLO, 32'h0, "R6 masked not summarised");
        chk(irq_cnt - base, 0, "R6 masked no pulse");
        wr(pa(12), 32'h1A);
        tick(3);
        chk(irq_cnt - base, 1, "R6 unmask reports");
        rd(A_SLO, 32'h8, "R6 group3 after unmask");
        wr(pa(12), 32'h300);
        pin(12, 1'b0);

        // R9 wake status
        wr(A_MST, 32'h1);
        base = irq_cnt;
        @(negedge clk) pin_wake[14] = 1'b1;
        @(negedge clk) pin_wake[14] = 1'b0;
        tick(3);
        rd(pa(14), 32'h200, "R9 wake captured");
        rd(A_SLO, 32'h8, "R9 wake summarised");
        chk(irq_cnt - base, 1, "R9 wake pulses");
        wr(pa(14), 32'h200);
        rd(pa(14), 32'h0, "R9 wake cleared");

        // R8 OR grouping
        wr(pa(0), 32'h1A);
        wr(pa(1), 32'h1A);
        @(negedge clk) pin_lvl[1:0] = 2'b11;
        tick(3);
        rd(A_SLO, 32'h1, "R8 two pins one bit");
        wr(pa(0), 32'h300);
        rd(A_SLO, 32'h1, "R8 one of two remains");
        wr(pa(1), 32'h300);
        rd(A_SLO, 32'h0, "R8 group empties");
        rd(A_SHI, 32'h0, "R8 high word");
        rd(12'h402, 32'h0, "R12 unaligned reads zero");
        rd(pa(15), 32'h0, "R2 last pin idle");
        tick(4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule